// File: doc/BRIEF.md
# Packet Ring Buffer Writer

This block takes a stream of fixed-length transport packets and stores each one as a record in a circular region of memory. Every record is a 4-byte prefix word followed by a 188-byte packet. The block writes it through a simple memory write port, one 32-bit word per beat. A host programs the region's lower bound, its inclusive upper bound and both pointers through a small register port. The host then drains records by moving the read pointer forward.

The write pointer always points at the next free record slot. It moves forward by one slot stride only after the last word of a record has gone out. The stride is the record length rounded up to a multiple of 8 bytes. Addresses wrap from the upper bound back to the lower bound on every word, so a record may straddle the end of the region. When storing a packet would make the write pointer catch up with the read pointer, the packet is discarded and a sticky overflow flag is set. A per-channel enable gates all writing. To restart, the host disables the channel, rewrites the bounds and pointers, and enables it again.

Top module: `pkt_ring_writer`

## Requirements
- R1: After reset the enable bit, the overflow flag, the lower bound, the upper bound and both pointers read as 0, and no memory write is issued.
- R2: A record begins on a beat with `pkt_sop` high. Its 48 words go to the write pointer plus 4×k for k = 0..47, in arrival order, and each word carries its input data unchanged.
- R3: Register index 5 reads the slot-size constant 192, which is 188 rounded up to a multiple of 8. Writes to that index have no effect.
- R4: The write pointer does not change while a record is in progress. It advances by the 192-byte stride in the same cycle that the record's last word appears on the memory port.
- R5: A word address that passes the inclusive upper bound continues at the lower bound. The write pointer wraps the same way.
- R6: A record is discarded when the free space (upper − lower + 1 minus occupancy) is 192 bytes or less. A discarded record causes no memory write, leaves the write pointer unchanged and sets overflow (control bit 1), which stays set.
- R7: Writing the control register (index 0) with bit 1 set clears the overflow flag. Bit 0 of the same write sets the enable.
- R8: A host write of the read pointer (index 4) frees space. Writing the lower bound into it after a wrap lets writing resume from the lower bound.
- R9: With enable (control bit 0) low, input beats cause no memory write and leave the write pointer unchanged. Clearing enable also abandons a record in progress.
- R10: A start beat that arrives during a record abandons that record without advancing the write pointer, and starts a new record at the same pointer.
- R11: Beats without `pkt_sop` that arrive while no record is open are ignored.
- R12: Indices 1, 2, 3 and 4 hold the lower bound, inclusive upper bound, write pointer and read pointer. Each reads back what the host last wrote, one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data for `host_addr` |
| pkt_valid | input | 1 | Input beat valid |
| pkt_sop | input | 1 | First beat of a record (prefix word) |
| pkt_data | input | 32 | Input beat data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| ring_enable | output | 1 | Current enable bit |

## Verification
The tests send whole records into an empty region, one after another, until the region fills. This shows that the write pointer moves a full stride per record and separates the one-slot-free limit from true overflow. A record sent after the host frees space lands exactly at the top of the region and wraps the pointer. A region whose size is not a multiple of the stride makes a record straddle the upper bound, which shows whether wrapping happens per word or only per slot. Truncated records, start beats arriving mid-record, stray beats and beats sent while disabled each show whether a write is correctly suppressed and whether a pointer is held.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_LOW  = 3'd1,
    RG_HIGH = 3'd2,
    RG_WPTR = 3'd3,
    RG_RPTR = 3'd4,
    RG_SLOT = 3'd5
  } ring_reg_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_OVF_BIT = 1;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import ring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLOT_VALUE = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [ADDR_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] host_rdata,
  input  logic              adv,
  input  logic [ADDR_W-1:0] adv_ptr,
  input  logic              ovf_set,
  output logic              enable,
  output logic              ovf,
  output logic [ADDR_W-1:0] low,
  output logic [ADDR_W-1:0] high,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr
);
  ring_reg_e sel;
  assign sel = ring_reg_e'(host_addr);

  logic wr_ctrl, wr_wptr;
  assign wr_ctrl = host_we && (sel == RG_CTRL);
  assign wr_wptr = host_we && (sel == RG_WPTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      ovf    <= 1'b0;
      low    <= '0;
      high   <= '0;
      wptr   <= '0;
      rptr   <= '0;
    end else begin
      if (wr_ctrl) enable <= host_wdata[CTRL_EN_BIT];
      if (wr_ctrl && host_wdata[CTRL_OVF_BIT]) ovf <= 1'b0;
      else if (ovf_set) ovf <= 1'b1;
      if (host_we && sel == RG_LOW)  low  <= host_wdata;
      if (host_we && sel == RG_HIGH) high <= host_wdata;
      if (host_we && sel == RG_RPTR) rptr <= host_wdata;
      if (wr_wptr) wptr <= host_wdata;
      else if (adv) wptr <= adv_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (sel)
        RG_CTRL: begin
          host_rdata <= '0;
          host_rdata[CTRL_EN_BIT]  <= enable;
          host_rdata[CTRL_OVF_BIT] <= ovf;
        end
        RG_LOW:  host_rdata <= low;
        RG_HIGH: host_rdata <= high;
        RG_WPTR: host_rdata <= wptr;
        RG_RPTR: host_rdata <= rptr;
        RG_SLOT: host_rdata <= ADDR_W'(SLOT_VALUE);
        default: host_rdata <= '0;
      endcase
    end
  end

  // R6: overflow flag stays set unless the host clears it
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf) && !($past(wr_ctrl) && $past(host_wdata[CTRL_OVF_BIT]))) |-> ovf);
  // R7: a clearing write always leaves the flag low
  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_ctrl) && $past(host_wdata[CTRL_OVF_BIT])) |-> !ovf);
  // R6: a committed record never lets the writer catch the reader
  a_r6_no_catchup: assert property (@(posedge clk) disable iff (rst)
    ($past(adv) && !$past(host_we)) |-> (wptr != rptr));
endmodule

// File: rtl/ring_space.sv
module ring_space #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 192
) (
  input  logic [ADDR_W-1:0] low,
  input  logic [ADDR_W-1:0] high,
  input  logic [ADDR_W-1:0] wptr,
  input  logic [ADDR_W-1:0] rptr,
  output logic [ADDR_W:0]   size,
  output logic              room
);
  logic [ADDR_W:0] used, free_b;

  always_comb begin
    size = {1'b0, high} - {1'b0, low} + (ADDR_W+1)'(1);
    if (wptr >= rptr) used = {1'b0, wptr} - {1'b0, rptr};
    else              used = size - ({1'b0, rptr} - {1'b0, wptr});
    free_b = size - used;
    room   = free_b > (ADDR_W+1)'(STRIDE);
  end
endmodule

// File: rtl/ring_writer.sv
module ring_writer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 48,
  parameter int STRIDE = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              room,
  input  logic [ADDR_W-1:0] low,
  input  logic [ADDR_W-1:0] high,
  input  logic [ADDR_W:0]   size,
  input  logic [ADDR_W-1:0] wptr,
  input  logic              pkt_valid,
  input  logic              pkt_sop,
  input  logic [DATA_W-1:0] pkt_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              adv,
  output logic [ADDR_W-1:0] adv_ptr,
  output logic              ovf_set
);
  localparam int BPB   = DATA_W / 8;
  localparam int SHIFT = $clog2(BPB);
  localparam int CNT_W = $clog2(BEATS);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] rec_ptr;

  function automatic logic [ADDR_W-1:0] wrap_add(
      input logic [ADDR_W-1:0] p, input logic [ADDR_W-1:0] inc,
      input logic [ADDR_W-1:0] hi, input logic [ADDR_W:0] sz);
    logic [ADDR_W:0] s;
    s = {1'b0, p} + {1'b0, inc};
    if (s > {1'b0, hi}) s = s - sz;
    return s[ADDR_W-1:0];
  endfunction

  logic start_ok, cont_beat, last_beat;
  assign start_ok  = enable && pkt_valid && pkt_sop && room;
  assign cont_beat = enable && pkt_valid && !pkt_sop && active;
  assign last_beat = cont_beat && (cnt == CNT_W'(BEATS-1));
  assign ovf_set   = enable && pkt_valid && pkt_sop && !room;
  assign adv       = last_beat;
  assign adv_ptr   = wrap_add(rec_ptr, ADDR_W'(STRIDE), high, size);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      rec_ptr   <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (!enable) begin
        active <= 1'b0;
      end else if (pkt_valid && pkt_sop) begin
        active <= room;
        if (start_ok) begin
          cnt       <= CNT_W'(1);
          rec_ptr   <= wptr;
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= pkt_data;
        end
      end else if (cont_beat) begin
        mem_we    <= 1'b1;
        mem_addr  <= wrap_add(rec_ptr, ADDR_W'(cnt) << SHIFT, high, size);
        mem_wdata <= pkt_data;
        if (last_beat) active <= 1'b0;
        else           cnt    <= cnt + CNT_W'(1);
      end
    end
  end

  // R9: nothing is written unless the channel was enabled
  a_r9_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(enable));
  // R6: a discarded record produces no write
  a_r6_drop_no_write: assert property (@(posedge clk) disable iff (rst)
    $past(ovf_set) |-> !mem_we);
  // R4: pointer advance only comes with the closing word of an open record
  a_r4_adv_at_end: assert property (@(posedge clk) disable iff (rst)
    adv |=> mem_we);
  // R11: a continuation beat with no open record writes nothing
  a_r11_stray_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(pkt_valid) && !$past(pkt_sop) && !$past(active)) |-> !mem_we);
endmodule

// File: rtl/pkt_ring_writer.sv
module pkt_ring_writer #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int HDR_BYTES = 4,
  parameter int PKT_BYTES = 188,
  parameter int ALIGN     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [ADDR_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] host_rdata,
  input  logic              pkt_valid,
  input  logic              pkt_sop,
  input  logic [DATA_W-1:0] pkt_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ring_enable
);
  localparam int REC_BYTES  = HDR_BYTES + PKT_BYTES;
  localparam int BPB        = DATA_W / 8;
  localparam int BEATS      = (REC_BYTES + BPB - 1) / BPB;
  localparam int STRIDE     = ((REC_BYTES + ALIGN - 1) / ALIGN) * ALIGN;
  localparam int SLOT_VALUE = ((PKT_BYTES + ALIGN - 1) / ALIGN) * ALIGN;

  logic              enable, ovf, room, adv, ovf_set;
  logic [ADDR_W-1:0] low, high, wptr, rptr, adv_ptr;
  logic [ADDR_W:0]   size;

  ring_regs #(.ADDR_W(ADDR_W), .SLOT_VALUE(SLOT_VALUE)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .adv(adv),
    .adv_ptr(adv_ptr), .ovf_set(ovf_set), .enable(enable), .ovf(ovf),
    .low(low), .high(high), .wptr(wptr), .rptr(rptr));

  ring_space #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_space (
    .low(low), .high(high), .wptr(wptr), .rptr(rptr), .size(size), .room(room));

  ring_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .STRIDE(STRIDE)) u_wr (
    .clk(clk), .rst(rst), .enable(enable), .room(room), .low(low), .high(high),
    .size(size), .wptr(wptr), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_data(pkt_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .adv(adv), .adv_ptr(adv_ptr), .ovf_set(ovf_set));

  assign ring_enable = enable;

  // R5: every word lands inside the programmed region
  a_r5_addr_in_region: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= $past(low) && mem_addr <= $past(high)));
endmodule

// File: tb/pkt_ring_writer_test.sv
module pkt_ring_writer_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1;
  logic        host_we = 0;
  logic [2:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        pkt_valid = 0, pkt_sop = 0;
  logic [31:0] pkt_data = 0;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        ring_enable;

  int checks = 0, fails = 0;
  logic [31:0] r_low, r_high;

  pkt_ring_writer uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] radd(input logic [31:0] p, input int inc);
    logic [32:0] s;
    s = {1'b0, p} + 33'(inc);
    if (s > {1'b0, r_high}) s = s - ({1'b0, r_high} - {1'b0, r_low} + 33'd1);
    return s[31:0];
  endfunction

  task automatic wr(input int idx, input logic [31:0] v);
    @(negedge clk);
    host_we = 1; host_addr = 3'(idx); host_wdata = v;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    host_addr = 3'(idx);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic setup(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] wp, input logic [31:0] rp);
    wr(0, 0);
    wr(1, lo); wr(2, hi); wr(3, wp); wr(4, rp);
    r_low = lo; r_high = hi;
    wr(0, 3);
  endtask

  // sends n beats; verifies each beat's write (or its absence) one cycle later
  task automatic send(input int n, input bit exp_wr, input logic [31:0] start, input int tag, output int errs);
    errs = 0;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        if (exp_wr) begin
          if (!mem_we || mem_addr != radd(start, 4*(k-1)) || mem_wdata != {16'(tag), 16'(k-1)}) begin
            errs++;
            $display("  beat %0d addr=0x%08h exp=0x%08h we=%0b", k-1, mem_addr, radd(start, 4*(k-1)), mem_we);
          end
        end else if (mem_we) errs++;
      end
      if (k < n) begin
        pkt_valid = 1; pkt_sop = (k == 0); pkt_data = {16'(tag), 16'(k)};
      end else begin
        pkt_valid = 0; pkt_sop = 0;
      end
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(mem_we == 0, "R1 no write in reset", 32'(mem_we), 0);
    rd(0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(3, v); check(v == 0, "R1 wptr", v, 0);
    rd(4, v); check(v == 0, "R1 rptr", v, 0);
    rd(5, v); check(v == 192, "R3 slot size", v, 192);
    wr(5, 32'h55); rd(5, v); check(v == 192, "R3 slot read-only", v, 192);
  endtask

  task automatic t_disabled;
    logic [31:0] v; int e;
    wr(1, 32'h1000); wr(2, 32'h15FF); wr(3, 32'h1000); wr(4, 32'h1000);
    r_low = 32'h1000; r_high = 32'h15FF;
    rd(1, v); check(v == 32'h1000, "R12 low", v, 32'h1000);
    rd(2, v); check(v == 32'h15FF, "R12 high", v, 32'h15FF);
    send(48, 0, 32'h1000, 1, e);
    check(e == 0, "R9 disabled writes", 32'(e), 0);
    rd(3, v); check(v == 32'h1000, "R9 wptr held", v, 32'h1000);
  endtask

  task automatic t_stray;
    int e = 0;
    wr(0, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k > 0 && mem_we) e++;
      pkt_valid = (k < 3); pkt_sop = 0; pkt_data = 32'hDEAD0000 + 32'(k);
    end
    check(e == 0, "R11 stray beats", 32'(e), 0);
  endtask

  task automatic t_abandon_and_first;
    logic [31:0] v; int e;
    send(20, 1, 32'h1000, 2, e);
    check(e == 0, "R2 partial words", 32'(e), 0);
    rd(3, v); check(v == 32'h1000, "R4 wptr held mid-record", v, 32'h1000);
    send(48, 1, 32'h1000, 3, e);
    check(e == 0, "R10 R2 restart record", 32'(e), 0);
    rd(3, v); check(v == 32'h10C0, "R4 wptr advance", v, 32'h10C0);
  endtask

  task automatic t_fill;
    logic [31:0] v; int e, bad = 0;
    for (int r = 1; r < 7; r++) begin
      send(48, 1, 32'h1000 + 32'(192*r), 10 + r, e);
      bad += e;
    end
    check(bad == 0, "R2 back-to-back records", 32'(bad), 0);
    rd(3, v); check(v == 32'h1540, "R4 wptr after seven", v, 32'h1540);
    send(48, 0, 32'h1540, 20, e);
    check(e == 0, "R6 drop no writes", 32'(e), 0);
    rd(3, v); check(v == 32'h1540, "R6 wptr unchanged", v, 32'h1540);
    rd(0, v); check(v == 3, "R6 overflow set", v, 3);
    wr(0, 3);
    rd(0, v); check(v == 1, "R7 overflow cleared", v, 1);
  endtask

  task automatic t_free_and_wrap;
    logic [31:0] v; int e;
    wr(4, 32'h1300);
    send(48, 1, 32'h1540, 30, e);
    check(e == 0, "R8 accept after free", 32'(e), 0);
    rd(3, v); check(v == 32'h1000, "R5 wptr wraps to low", v, 32'h1000);
    wr(4, 32'h1000);
    send(48, 1, 32'h1000, 31, e);
    check(e == 0, "R8 rptr at low resumes", 32'(e), 0);
    rd(3, v); check(v == 32'h10C0, "R8 wptr", v, 32'h10C0);
  endtask

  task automatic t_straddle;
    logic [31:0] v; int e;
    setup(32'h2000, 32'h2607, 32'h2600, 32'h2300);
    send(48, 1, 32'h2600, 40, e);
    check(e == 0, "R5 per-word wrap", 32'(e), 0);
    rd(3, v); check(v == 32'h20B8, "R5 wptr straddle", v, 32'h20B8);
  endtask

  task automatic t_disable_mid;
    logic [31:0] v; int e;
    send(10, 1, 32'h20B8, 50, e);
    wr(0, 0);
    send(48, 0, 32'h20B8, 51, e);
    check(e == 0, "R9 disabled mid-record", 32'(e), 0);
    rd(3, v); check(v == 32'h20B8, "R9 wptr after abandon", v, 32'h20B8);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    r_low = 0; r_high = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_disabled();
    t_stray();
    t_abandon_and_first();
    t_fill();
    t_free_and_wrap();
    t_straddle();
    t_disable_mid();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule